// File: doc/BRIEF.md
# Converter Power-Mode Supervisor

This block is the operating-state sequencer of a low-power data converter. It brings the analog section up after reset, holds off all work for a fixed settling interval, then waits in a ready state for software commands. From ready it launches either a conversion or a calibration by pulsing a start line to the matching unit, and it returns to ready when that unit reports done. A sleep command powers the analog section down and lets the digital clock be gated. Leaving sleep always repeats the full settling interval.

Command inputs are single-cycle request pulses from a register interface, plus a sleep level. A request that arrives while the supervisor cannot serve it is held until the next ready state. When both kinds of work are wanted at once, calibration is served first. A 3-bit status code reports the current state so that software can read it back. The clock-gating cell and the bus interface are outside this block.

Top module: `pwr_mode_sup`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the state is RESET. In RESET, status is 0, ana_en is 0, data_clr is 1 and no start pulse is issued. Both pending requests are cleared.
- R2: The state after RESET is WAKE (status 1), with ana_en at 1. WAKE lasts exactly SETTLE_CYCLES clock cycles, then the state moves to READY (status 2).
- R3: conv_start and cal_start are single-cycle pulses. Each is high only in the first cycle of CONV (status 3) or CAL (status 4), and only when the previous state was READY.
- R4: In CONV, conv_done sampled high at a clock edge returns the state to READY at that edge. In CAL, cal_done does the same. Otherwise the state stays where it is.
- R5: When a calibration and a conversion are both wanted in READY, CAL is entered first and the conversion stays pending.
- R6: A request pulse that arrives outside READY is held until a READY state serves it. This includes requests during WAKE, CONV, CAL and SLEEP. A request pulse present in READY is served at that same edge.
- R7: sleep_req high in READY moves the state to SLEEP (status 5), with ana_en at 0. Sleep takes precedence over pending requests. sleep_req has no effect in CONV or CAL until the state is back in READY.
- R8: In SLEEP, sleep_req low moves the state to WAKE, and the full SETTLE_CYCLES interval runs again before READY.
- R9: clk_gate_en is low only when all of the following hold: the state is SLEEP, sleep_req is high, rst_n is high, and neither request input is high. In every other case clk_gate_en is high.
- R10: status codes are RESET=0, WAKE=1, READY=2, CONV=3, CAL=4 and SLEEP=5. ana_en is 1 in every state except RESET and SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Level: request power-down |
| conv_req | input | 1 | Pulse: request a conversion |
| cal_req | input | 1 | Pulse: request a calibration |
| conv_done | input | 1 | Conversion unit finished |
| cal_done | input | 1 | Calibration unit finished |
| ana_en | output | 1 | Analog section power enable |
| clk_gate_en | output | 1 | Enable for the digital clock gate |
| data_clr | output | 1 | Clear for the data registers |
| conv_start | output | 1 | Start pulse to the conversion unit |
| cal_start | output | 1 | Start pulse to the calibration unit |
| status | output | 3 | Current state code |

## Verification
Several events can coincide in one cycle. A conversion request can meet a calibration request. A sleep command can meet a pending request at the READY decision. A new request can meet the wake-up condition while asleep. The bench drives each of these pairs at the same clock edge. For the two requests it expects CAL, with the conversion following one READY cycle later. For sleep against a request it expects SLEEP, with the request still held after wake-up. For a request during sleep it expects clk_gate_en to rise at once. A behavioural reference model is compared with every output on every clock, so a wrong winner shows up as a status mismatch in the cycle concerned.

// File: rtl/pms_pkg.sv
package pms_pkg;

    // State codes double as the status value read back by software.
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_WAKE  = 3'd1,
        ST_READY = 3'd2,
        ST_CONV  = 3'd3,
        ST_CAL   = 3'd4,
        ST_SLEEP = 3'd5
    } pms_state_e;

    typedef struct packed {
        logic conv;
        logic cal;
    } pms_pend_t;

    typedef struct packed {
        pms_state_e st;
        logic       conv_start;
        logic       cal_start;
    } pms_fsm_t;

endpackage

// File: rtl/pms_settle_timer.sv
module pms_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 2800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic settled
);
    localparam int unsigned CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled = run && (cnt_q == LAST);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/pms_req_arb.sv
module pms_req_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_req,
    input  logic cal_req,
    input  logic conv_grant,
    input  logic cal_grant,
    output logic want_conv,
    output logic want_cal,
    output logic pick_conv,
    output logic pick_cal
);
    import pms_pkg::*;

    pms_pend_t pend_d, pend_q;

    always_comb begin
        want_conv   = pend_q.conv | conv_req;
        want_cal    = pend_q.cal  | cal_req;
        // calibration wins a tie
        pick_cal    = want_cal;
        pick_conv   = want_conv & ~want_cal;
        pend_d.conv = want_conv & ~conv_grant;
        pend_d.cal  = want_cal  & ~cal_grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R6
    conv_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_grant |=> want_conv);

    // R6
    cal_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req && !cal_grant |=> want_cal);

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                conv_req,
    input  logic                cal_req,
    input  logic                conv_done,
    input  logic                cal_done,
    input  logic                settled,
    input  logic                pick_conv,
    input  logic                pick_cal,
    output pms_pkg::pms_state_e state_o,
    output logic                timer_run,
    output logic                conv_grant,
    output logic                cal_grant,
    output logic                ana_en,
    output logic                clk_gate_en,
    output logic                data_clr,
    output logic                conv_start,
    output logic                cal_start
);
    import pms_pkg::*;

    pms_fsm_t fsm_d, fsm_q;
    logic     go_sleep;

    always_comb begin
        fsm_d            = fsm_q;
        fsm_d.conv_start = 1'b0;
        fsm_d.cal_start  = 1'b0;
        go_sleep         = (fsm_q.st == ST_READY) && sleep_req;
        conv_grant       = 1'b0;
        cal_grant        = 1'b0;
        unique case (fsm_q.st)
            ST_RESET: fsm_d.st = ST_WAKE;
            ST_WAKE:  if (settled) fsm_d.st = ST_READY;
            ST_READY: begin
                if (go_sleep) begin
                    fsm_d.st = ST_SLEEP;
                end else if (pick_cal) begin
                    fsm_d.st        = ST_CAL;
                    fsm_d.cal_start = 1'b1;
                    cal_grant       = 1'b1;
                end else if (pick_conv) begin
                    fsm_d.st         = ST_CONV;
                    fsm_d.conv_start = 1'b1;
                    conv_grant       = 1'b1;
                end
            end
            ST_CONV:  if (conv_done) fsm_d.st = ST_READY;
            ST_CAL:   if (cal_done)  fsm_d.st = ST_READY;
            ST_SLEEP: if (!sleep_req) fsm_d.st = ST_WAKE;
            default:  fsm_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st         <= ST_RESET;
            fsm_q.conv_start <= 1'b0;
            fsm_q.cal_start  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o     = fsm_q.st;
    assign timer_run   = (fsm_q.st == ST_WAKE);
    assign ana_en      = (fsm_q.st != ST_RESET) && (fsm_q.st != ST_SLEEP);
    assign data_clr    = (fsm_q.st == ST_RESET);
    assign conv_start  = fsm_q.conv_start;
    assign cal_start   = fsm_q.cal_start;
    // keep the clock while any wake, reset or request event is pending
    assign clk_gate_en = !((fsm_q.st == ST_SLEEP) && sleep_req && rst_n
                           && !conv_req && !cal_req);

    // R3
    conv_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> fsm_q.st == ST_CONV && $past(fsm_q.st) == ST_READY);

    // R3
    cal_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> fsm_q.st == ST_CAL && $past(fsm_q.st) == ST_READY);

    // R5
    cal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.st == ST_CONV && $past(fsm_q.st) == ST_READY |-> !$past(pick_cal));

    // R2
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsm_q.st) == ST_WAKE && fsm_q.st == ST_READY |-> $past(settled));

    // R8
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsm_q.st) == ST_SLEEP && fsm_q.st != ST_SLEEP |-> fsm_q.st == ST_WAKE);

    // R4
    conv_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsm_q.st) == ST_CONV && $past(conv_done) |-> fsm_q.st == ST_READY);

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_gate_en |=> fsm_q.st == ST_SLEEP);

endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup #(
    parameter int unsigned SETTLE_CYCLES = 2800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       conv_req,
    input  logic       cal_req,
    input  logic       conv_done,
    input  logic       cal_done,
    output logic       ana_en,
    output logic       clk_gate_en,
    output logic       data_clr,
    output logic       conv_start,
    output logic       cal_start,
    output logic [2:0] status
);
    import pms_pkg::*;

    pms_state_e st;
    logic timer_run, settled;
    logic conv_grant, cal_grant;
    logic want_conv, want_cal, pick_conv, pick_cal;

    pms_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .settled (settled)
    );

    pms_req_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_req   (conv_req),
        .cal_req    (cal_req),
        .conv_grant (conv_grant),
        .cal_grant  (cal_grant),
        .want_conv  (want_conv),
        .want_cal   (want_cal),
        .pick_conv  (pick_conv),
        .pick_cal   (pick_cal)
    );

    pms_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .conv_req    (conv_req),
        .cal_req     (cal_req),
        .conv_done   (conv_done),
        .cal_done    (cal_done),
        .settled     (settled),
        .pick_conv   (pick_conv),
        .pick_cal    (pick_cal),
        .state_o     (st),
        .timer_run   (timer_run),
        .conv_grant  (conv_grant),
        .cal_grant   (cal_grant),
        .ana_en      (ana_en),
        .clk_gate_en (clk_gate_en),
        .data_clr    (data_clr),
        .conv_start  (conv_start),
        .cal_start   (cal_start)
    );

    assign status = st;

    // R6
    pick_needs_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(want_conv));

endmodule

// File: tb/pwr_mode_sup_bench.sv
`timescale 1ns/100ps
module pwr_mode_sup_bench;
    localparam int SET = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, conv_req = 1'b0, cal_req = 1'b0;
    logic conv_done = 1'b0, cal_done = 1'b0;
    logic ana_en, clk_gate_en, data_clr, conv_start, cal_start;
    logic [2:0] status;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // behavioural reference state
    int m_st = 0, m_cnt = 0;
    bit m_pc = 0, m_pk = 0, m_cs = 0, m_ks = 0;

    always #2 clk = ~clk;

    pwr_mode_sup #(.SETTLE_CYCLES(SET)) u_pwr_mode_sup (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .conv_req(conv_req),
        .cal_req(cal_req), .conv_done(conv_done), .cal_done(cal_done),
        .ana_en(ana_en), .clk_gate_en(clk_gate_en), .data_clr(data_clr),
        .conv_start(conv_start), .cal_start(cal_start), .status(status)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_pk = 0; m_cs = 0; m_ks = 0;
        end else begin
            bit wc, wk, gc, gk;
            int nst;
            wc = m_pc | conv_req; wk = m_pk | cal_req;
            gc = 0; gk = 0; nst = m_st;
            if (m_st == 0) nst = 1;
            else if (m_st == 1) begin
                if (m_cnt == SET - 1) nst = 2;
            end else if (m_st == 2) begin
                if (sleep_req) nst = 5;
                else if (wk) begin nst = 4; gk = 1; end
                else if (wc) begin nst = 3; gc = 1; end
            end else if (m_st == 3) begin
                if (conv_done) nst = 2;
            end else if (m_st == 4) begin
                if (cal_done) nst = 2;
            end else if (m_st == 5) begin
                if (!sleep_req) nst = 1;
            end
            m_cnt = (m_st == 1 && nst == 1) ? m_cnt + 1 : 0;
            m_pc = wc & !gc; m_pk = wk & !gk;
            m_cs = gc; m_ks = gk;
            m_st = nst;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int cg;
        cg = !(m_st == 5 && sleep_req && rst_n && !conv_req && !cal_req);
        chk("R10 status", int'(status), m_st);
        chk("R7 ana_en", int'(ana_en), int'(m_st != 0 && m_st != 5));
        chk("R1 data_clr", int'(data_clr), int'(m_st == 0));
        chk("R3 conv_start", int'(conv_start), int'(m_cs));
        chk("R3 cal_start", int'(cal_start), int'(m_ks));
        chk("R9 clk_gate_en", int'(clk_gate_en), cg);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        check_all();
    endtask

    task automatic wait_ready(input bit pulse_conv, output int nwake);
        nwake = 0;
        for (int i = 0; i < 4 * SET + 10; i++) begin
            if (pulse_conv && nwake == 3) conv_req = 1'b1;
            step();
            conv_req = 1'b0;
            if (status == 3'd1) nwake++;
            if (status == 3'd2) break;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000 && !finished) begin
            bad++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) step();
        chk("R1 status in reset", int'(status), 0);
        chk("R1 data_clr in reset", int'(data_clr), 1);
        rst_n = 1'b1;
        // R2 wake length, R6 conversion request held during wake
        wait_ready(1'b1, n);
        chk("R2 wake cycles", n, SET);
        step();
        chk("R6 held conv served", int'(status), 3);
        chk("R3 conv pulse", int'(conv_start), 1);
        step();
        chk("R3 pulse single", int'(conv_start), 0);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        chk("R4 back to ready", int'(status), 2);
        // R5: tie
        conv_req = 1'b1; cal_req = 1'b1; step(); conv_req = 1'b0; cal_req = 1'b0;
        chk("R5 cal wins", int'(status), 4);
        step();
        cal_done = 1'b1; step(); cal_done = 1'b0;
        chk("R4 cal return", int'(status), 2);
        step();
        chk("R5 conv follows", int'(status), 3);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        // R6: conv during cal
        cal_req = 1'b1; step(); cal_req = 1'b0;
        conv_req = 1'b1; step(); conv_req = 1'b0;
        step();
        chk("R6 still cal", int'(status), 4);
        cal_done = 1'b1; step(); cal_done = 1'b0;
        step();
        chk("R6 conv after cal", int'(status), 3);
        // R7: sleep ignored during conversion
        sleep_req = 1'b1;
        repeat (3) step();
        chk("R7 sleep ignored in conv", int'(status), 3);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        step();
        chk("R7 sleep entered", int'(status), 5);
        chk("R7 analog off", int'(ana_en), 0);
        chk("R9 gated in sleep", int'(clk_gate_en), 0);
        // R9: request in sleep keeps clock, R6 request held
        cal_req = 1'b1; #0.5;
        chk("R9 request ungates", int'(clk_gate_en), 1);
        step(); cal_req = 1'b0;
        step();
        chk("R6 held in sleep", int'(status), 5);
        sleep_req = 1'b0; #0.5;
        chk("R9 wake ungates", int'(clk_gate_en), 1);
        // R8: full wake again
        wait_ready(1'b0, n);
        chk("R8 rewake cycles", n, SET);
        step();
        chk("R6 cal after sleep", int'(status), 4);
        cal_done = 1'b1; step(); cal_done = 1'b0;
        // R7: sleep beats a request in the same cycle
        sleep_req = 1'b1; conv_req = 1'b1; step(); conv_req = 1'b0;
        chk("R7 sleep priority", int'(status), 5);
        step();
        sleep_req = 1'b0;
        wait_ready(1'b0, n);
        step();
        chk("R7 conv kept over sleep", int'(status), 3);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        // R1/R6: reset clears pending
        sleep_req = 1'b1; step();
        cal_req = 1'b1; step(); cal_req = 1'b0;
        rst_n = 1'b0; sleep_req = 1'b0; step();
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset analog off", int'(ana_en), 0);
        rst_n = 1'b1;
        wait_ready(1'b0, n);
        repeat (3) step();
        chk("R6 reset cleared pending", int'(status), 2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule